// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates among eight level-sensitive interrupt request lines. Each cycle the request lines are captured into a request register. Requests are then filtered by a software-written mask byte and by the levels already being serviced. The highest-priority survivor drives a single interrupt line toward the processor, together with its 3-bit level number.

When the processor acknowledges, that level is recorded as in service. It stays in service until software issues an end-of-interrupt command.

Priority is held as a pointer to the current lowest-priority level. The level just after the pointer, counting upward and wrapping modulo eight, is the highest. Commands can move the pointer automatically at end-of-interrupt or to an explicit level. A special mask mode lets software open lower levels while a higher one is still in service. Bus decoding, vector generation and cascading are handled elsewhere.

Top module: `irq_resolver`

## Requirements
- R1: After reset the request, in-service and mask registers read 0 and the interrupt output is low. The lowest-priority pointer is 7, so level 0 is highest and level 7 lowest.
- R2: The request register copies the request lines on every clock edge. A request that drops is cleared at the next edge, with no edge detection.
- R3: A mask write loads the mask register. A set mask bit stops only its own level from raising the interrupt output; other levels are unaffected.
- R4: The rank of level L is (L - pointer - 1) mod 8, and rank 0 wins. The interrupt output and the winning level are derived combinationally from the registered requests.
- R5: An acknowledge while the interrupt output is high sets the in-service bit of the winning level. An acknowledge while it is low changes nothing.
- R6: Outside special mask mode, a set in-service bit blocks requests of equal or lower rank. A strictly higher-ranked unmasked request still raises the interrupt output.
- R7: Command code 1 (nonspecific end-of-interrupt) clears the in-service bit of lowest rank that is set.
- R8: Command code 2 (specific end-of-interrupt) clears the in-service bit at the supplied level.
- R9: Command code 3 (rotate on nonspecific end-of-interrupt) clears the in-service bit of lowest rank and moves the pointer to that level.
- R10: Command code 4 (set priority) moves the pointer to the supplied level. Command code 5 (rotate on specific end-of-interrupt) clears that level's in-service bit and also moves the pointer there.
- R11: Command code 6 enters special mask mode and code 7 leaves it; code 0 does nothing. In that mode an in-service bit blocks only its own level. A nonspecific end-of-interrupt skips in-service bits whose mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 8 | Level-sensitive request lines |
| mask_wr_i | input | 1 | Load strobe for the mask register |
| mask_data_i | input | 8 | New mask value |
| ack_i | input | 1 | Processor acknowledge strobe |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 3 | Command code (0..7) |
| cmd_level_i | input | 3 | Level operand of the command |
| irq_o | output | 1 | Interrupt to the processor |
| win_level_o | output | 3 | Winning level, meaningful while irq_o is high |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| imr_o | output | 8 | Mask register |

## Verification
Several rules are checked on every cycle:
- a granted level is never already in service;
- a fully masked block stays silent;
- acknowledges set exactly the winning bit, or nothing when idle;
- a nonspecific end-of-interrupt removes exactly one bit;
- specific end-of-interrupt and pointer loads take effect on the next edge.

The actual rank order under a moved pointer, nested preemption, and how special mask mode treats masked in-service bits depend on chosen command sequences. Only the bench scenarios show these behaviours, by comparing the winning level against orders computed independently.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned DEF_LEVELS = 8;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_EOI_NS   = 3'd1,
    CMD_EOI_SP   = 3'd2,
    CMD_ROT_NS   = 3'd3,
    CMD_SET_PRIO = 3'd4,
    CMD_ROT_SP   = 3'd5,
    CMD_SMM_ON   = 3'd6,
    CMD_SMM_OFF  = 3'd7
  } cmd_e;
endpackage

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] irr_o
);
  // Level sensitive: the register simply samples the lines each cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_o <= '0;
    else        irr_o <= req_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 8,
  parameter int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] ptr_i,
  output logic         valid_o,
  output logic [W-1:0] level_o
);
  logic [N-1:0] hit;     // hit[d]: bit with rank d is set
  logic [W-1:0] sel;

  // Level holding rank d, given the lowest-priority pointer.
  function automatic logic [W-1:0] level_at(input logic [W-1:0] d, input logic [W-1:0] ptr);
    return ptr + W'(1) + d;
  endfunction

  for (genvar d = 0; d < N; d++) begin : g_rank
    logic [W-1:0] idx;
    assign idx    = level_at(W'(d), ptr_i);
    assign hit[d] = vec_i[idx];
  end

  always_comb begin
    sel = '0;
    for (int d = N - 1; d >= 0; d--) begin
      if (hit[d]) sel = W'(d);
    end
  end

  assign valid_o = |hit;
  assign level_o = level_at(sel, ptr_i);

  // R4: a reported winner always names a set bit of the input vector
  always_comb begin
    if (valid_o) p_pick_hits_r4: assert (vec_i[level_o]);
  end
endmodule

// File: rtl/irq_isr_ctrl.sv
module irq_isr_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_i,
  input  logic         ack_ok_i,
  input  logic [W-1:0] ack_level_i,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_code_i,
  input  logic [W-1:0] cmd_level_i,
  input  logic [N-1:0] imr_i,
  output logic [N-1:0] isr_o,
  output logic [W-1:0] ptr_o,
  output logic         smm_o
);
  cmd_e         code;
  logic [N-1:0] isr_q, isr_d, set_v, clr_v, eoi_vec;
  logic [W-1:0] ptr_q, ptr_d, eoi_level;
  logic         smm_q, smm_d, eoi_valid;

  assign code = cmd_e'(cmd_code_i);

  // Target of a nonspecific end-of-interrupt; masked bits skipped in special mask mode.
  assign eoi_vec = smm_q ? (isr_q & ~imr_i) : isr_q;

  irq_prio_pick #(.N(N), .W(W)) u_eoi_pick (
    .vec_i   (eoi_vec),
    .ptr_i   (ptr_q),
    .valid_o (eoi_valid),
    .level_o (eoi_level)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    ptr_d = ptr_q;
    smm_d = smm_q;
    if (ack_i && ack_ok_i) set_v[ack_level_i] = 1'b1;
    if (cmd_valid_i) begin
      case (code)
        CMD_EOI_NS:   if (eoi_valid) clr_v[eoi_level] = 1'b1;
        CMD_EOI_SP:   clr_v[cmd_level_i] = 1'b1;
        CMD_ROT_NS:   if (eoi_valid) begin
                        clr_v[eoi_level] = 1'b1;
                        ptr_d = eoi_level;
                      end
        CMD_SET_PRIO: ptr_d = cmd_level_i;
        CMD_ROT_SP:   begin
                        clr_v[cmd_level_i] = 1'b1;
                        ptr_d = cmd_level_i;
                      end
        CMD_SMM_ON:   smm_d = 1'b1;
        CMD_SMM_OFF:  smm_d = 1'b0;
        default:      ;
      endcase
    end
    isr_d = (isr_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      ptr_q <= W'(N - 1);
      smm_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      ptr_q <= ptr_d;
      smm_q <= smm_d;
    end
  end

  assign isr_o = isr_q;
  assign ptr_o = ptr_q;
  assign smm_o = smm_q;

  // R8: specific end-of-interrupt leaves the named bit clear
  p_spec_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && code == CMD_EOI_SP && !ack_i) |=> !isr_q[$past(cmd_level_i)]);

  // R10: set priority and rotate-on-specific load the pointer
  p_ptr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && (code == CMD_SET_PRIO || code == CMD_ROT_SP)) |=> ptr_q == $past(cmd_level_i));

  // R9: rotate-on-nonspecific moves the pointer to the level it cleared
  p_rot_ns_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && code == CMD_ROT_NS && eoi_valid) |=> ptr_q == $past(eoi_level));

  // R7: nonspecific end-of-interrupt removes exactly one in-service bit
  p_ns_eoi_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && code == CMD_EOI_NS && !ack_i && !smm_q && isr_q != '0)
    |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_prio_pkg::*;
#(
  parameter int unsigned N = DEF_LEVELS,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_data_i,
  input  logic         ack_i,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_code_i,
  input  logic [W-1:0] cmd_level_i,
  output logic         irq_o,
  output logic [W-1:0] win_level_o,
  output logic [N-1:0] irr_o,
  output logic [N-1:0] isr_o,
  output logic [N-1:0] imr_o
);
  logic [N-1:0] irr, isr, imr_q, pending;
  logic [W-1:0] ptr, req_level, top_level;
  logic         smm, req_valid, top_valid, outranks;

  // Rank of a level against the pointer: 0 is the highest priority.
  function automatic logic [W-1:0] rank_of(input logic [W-1:0] lvl, input logic [W-1:0] p);
    return lvl - p - W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         imr_q <= '0;
    else if (mask_wr_i) imr_q <= mask_data_i;
  end

  irq_req_stage #(.N(N)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .irr_o (irr)
  );

  // In special mask mode a level's own in-service bit still holds it back.
  assign pending = irr & ~imr_q & (smm ? ~isr : {N{1'b1}});

  irq_prio_pick #(.N(N), .W(W)) u_req_pick (
    .vec_i   (pending),
    .ptr_i   (ptr),
    .valid_o (req_valid),
    .level_o (req_level)
  );

  irq_prio_pick #(.N(N), .W(W)) u_isr_pick (
    .vec_i   (isr),
    .ptr_i   (ptr),
    .valid_o (top_valid),
    .level_o (top_level)
  );

  assign outranks = !top_valid || (rank_of(req_level, ptr) < rank_of(top_level, ptr));
  assign irq_o    = req_valid && (smm || outranks);

  irq_isr_ctrl #(.N(N), .W(W)) u_isr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .ack_ok_i    (irq_o),
    .ack_level_i (req_level),
    .cmd_valid_i (cmd_valid_i),
    .cmd_code_i  (cmd_code_i),
    .cmd_level_i (cmd_level_i),
    .imr_i       (imr_q),
    .isr_o       (isr),
    .ptr_o       (ptr),
    .smm_o       (smm)
  );

  assign win_level_o = req_level;
  assign irr_o       = irr;
  assign isr_o       = isr;
  assign imr_o       = imr_q;

  // R5: a granted acknowledge marks the winner in service
  p_ack_sets_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !cmd_valid_i) |=> isr_o[$past(win_level_o)]);

  // R5: an acknowledge with no interrupt pending leaves in-service untouched
  p_ack_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !cmd_valid_i) |=> isr_o == $past(isr_o));

  // R6: a level already in service is never granted again
  p_no_self_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !isr_o[win_level_o]);

  // R3: with every level masked the processor line stays low
  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_o == {N{1'b1}}) |-> !irq_o);
endmodule

// File: tb/irq_resolver_tb_top.sv
module irq_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {req, mask, expected irq, expected level}
  localparam logic [19:0] VECS [NVEC] = '{
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h80, 8'h00, 1'b1, 3'd7},
    {8'hA4, 8'h00, 1'b1, 3'd2},
    {8'hA4, 8'h04, 1'b1, 3'd5},
    {8'hA4, 8'hA4, 1'b0, 3'd0},
    {8'hFF, 8'h7F, 1'b1, 3'd7},
    {8'h18, 8'h00, 1'b1, 3'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req = '0, mask_data = '0;
  logic mask_wr = 1'b0, ack = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0, cmd_level = '0;
  logic irq;
  logic [2:0] win_level;
  logic [7:0] irr, isr, imr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .ack_i(ack), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_level_i(cmd_level),
    .irq_o(irq), .win_level_o(win_level), .irr_o(irr), .isr_o(isr), .imr_o(imr)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(string tag, logic exp_irq, logic [2:0] exp_lvl);
    checks++;
    if (irq !== exp_irq || (exp_irq && win_level !== exp_lvl)) begin
      errors++;
      $display("FAIL %s: actual irq=%0b lvl=%0d expected irq=%0b lvl=%0d",
               tag, irq, win_level, exp_irq, exp_lvl);
    end
  endtask

  task automatic set_mask(logic [7:0] m);
    mask_wr = 1'b1; mask_data = m; tick(); mask_wr = 1'b0;
  endtask

  task automatic set_req(logic [7:0] r);
    req = r; tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_cmd(logic [2:0] code, logic [2:0] lvl);
    cmd_valid = 1'b1; cmd_code = code; cmd_level = lvl; tick(); cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk8("R1 isr", isr, 8'h00);
    chk8("R1 imr", imr, 8'h00);
    chk8("R1 irr", irr, 8'h00);
    chk_irq("R1 idle", 1'b0, 3'd0);

    // R4 / R3 table walk with the reset priority order
    for (int i = 0; i < NVEC; i++) begin
      set_mask(VECS[i][11:4]);
      set_req(VECS[i][19:12]);
      chk_irq($sformatf("R4 vector %0d", i), VECS[i][3], VECS[i][2:0]);
    end
    set_mask(8'h00);
    set_req(8'h00);

    // R5 / R6 nesting
    set_req(8'h10);
    do_ack();
    chk8("R5 ack sets bit", isr, 8'h10);
    chk_irq("R6 same level blocked", 1'b0, 3'd0);
    set_req(8'h50);
    chk_irq("R6 lower blocked", 1'b0, 3'd0);
    set_req(8'h54);
    chk_irq("R6 higher preempts", 1'b1, 3'd2);
    set_req(8'h10);
    do_ack();
    chk8("R5 idle ack ignored", isr, 8'h10);
    set_req(8'h14);
    do_ack();
    chk8("R5 nested ack", isr, 8'h14);
    set_req(8'h00);
    do_cmd(3'd1, 3'd0);
    chk8("R7 nonspecific eoi", isr, 8'h10);
    do_cmd(3'd2, 3'd4);
    chk8("R8 specific eoi", isr, 8'h00);

    // R9 rotate on nonspecific eoi: level 4 becomes lowest
    set_req(8'h10);
    do_ack();
    set_req(8'h00);
    do_cmd(3'd3, 3'd0);
    chk8("R9 rotate clears", isr, 8'h00);
    set_req(8'h11);
    chk_irq("R9 level 0 over 4", 1'b1, 3'd0);
    set_req(8'h30);
    chk_irq("R9 level 5 highest", 1'b1, 3'd5);

    // R10 set priority with level 5 lowest
    do_cmd(3'd4, 3'd5);
    set_req(8'h41);
    chk_irq("R10 level 6 highest", 1'b1, 3'd6);
    set_req(8'h30);
    chk_irq("R10 level 5 lowest", 1'b1, 3'd4);
    do_ack();
    chk8("R10 ack level 4", isr, 8'h10);
    do_cmd(3'd5, 3'd4);
    chk8("R10 rotate specific clears", isr, 8'h00);
    chk_irq("R10 level 5 now highest", 1'b1, 3'd5);
    do_cmd(3'd4, 3'd7);
    set_req(8'h00);

    // R11 special mask mode
    set_req(8'h01);
    do_ack();
    set_req(8'h81);
    chk_irq("R11 normal mode blocks", 1'b0, 3'd0);
    do_cmd(3'd0, 3'd0);
    chk8("R11 nop keeps isr", isr, 8'h01);
    do_cmd(3'd6, 3'd0);
    chk_irq("R11 lower level opens", 1'b1, 3'd7);
    do_ack();
    chk8("R11 second bit in service", isr, 8'h81);
    chk_irq("R11 own bits block", 1'b0, 3'd0);
    set_mask(8'h01);
    do_cmd(3'd1, 3'd0);
    chk8("R11 eoi skips masked bit", isr, 8'h01);
    do_cmd(3'd7, 3'd0);
    set_mask(8'h00);
    do_cmd(3'd2, 3'd0);
    chk8("R11 cleanup", isr, 8'h00);
    set_req(8'h00);

    // R3 one masked level does not disturb its neighbours
    set_mask(8'h02);
    set_req(8'h02);
    chk_irq("R3 masked level silent", 1'b0, 3'd0);
    chk8("R3 request still latched", irr, 8'h02);
    set_req(8'h06);
    chk_irq("R3 neighbour unaffected", 1'b1, 3'd2);
    set_mask(8'h00);

    // R2 level tracking
    set_req(8'h08);
    chk8("R2 request captured", irr, 8'h08);
    set_req(8'h00);
    chk8("R2 request dropped", irr, 8'h00);
    chk_irq("R2 no interrupt after drop", 1'b0, 3'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule